// File: doc/BRIEF.md
# Matrix Array Group-Zeroing Sequencer

This block turns one 32-bit command word into a sequence of row-clear strobes for a square tile array of storage rows. The command comes in three forms, which clear one, two or four groups of four adjacent rows. A two-bit field in the word picks one of four 32-bit select registers. These registers arrive as inputs. The chosen value, plus a small immediate offset, fixes the first row. The storage array, enable checks and pipeline sit outside the block.

The array has `VLEN_BITS / 8` rows. The groups are spread evenly over the array, so each form covers the whole array, its halves or its quarters. The start row wraps inside one such span and is then aligned down to a multiple of four. After a command is accepted, the block issues one strobe per cycle with a row index, then pulses `done`. A word that fits none of the three forms raises `undef` and issues no strobes.

Top module: `tile_rowclr_seq`

## Requirements
- R1: A word with bits 31..15 = 17'b11000000000011101 and bits 12..2 all zero is the single-group form. It clears exactly 4 rows. Its offset is bits 1..0 times 4.
- R2: A word with bits 31..15 = 17'b11000000000011110 and bits 12..1 all zero is the two-group form. It clears exactly 8 rows. Its offset is bit 0 times 4.
- R3: A word with bits 31..15 = 17'b11000000000011111 and bits 12..1 all zero is the four-group form. It clears exactly 16 rows. Its offset is bit 0 times 4.
- R4: Bits 14..13 (value n) select input `sel_reg{n}` as the base value.
- R5: The stride is ROWS / groups, where ROWS = VLEN_BITS/8. The first row is ((base + offset) mod 2^32, then mod stride), rounded down to a multiple of 4.
- R6: Rows are issued group by group. Each group is four ascending rows, and group g starts at first row + g*stride.
- R7: The first strobe comes in the cycle after the accepting edge. Strobes then follow one per cycle with no gap. `done` is high for exactly one cycle, in the cycle after the last strobe.
- R8: Any other word, including a valid pattern with a set must-be-zero bit, raises `undef` for one cycle in the cycle after acceptance. It issues no strobe.
- R9: `busy` is high during every strobe cycle. A `cmd_valid` while busy is ignored: the running sequence is unchanged, and no strobe and no `undef` follow from it.
- R10: After reset, `busy`, `row_clr`, `done` and `undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Command word |
| sel_reg0 | input | 32 | Select register chosen by field value 0 |
| sel_reg1 | input | 32 | Select register chosen by field value 1 |
| sel_reg2 | input | 32 | Select register chosen by field value 2 |
| sel_reg3 | input | 32 | Select register chosen by field value 3 |
| busy | output | 1 | Sequence in progress |
| row_clr | output | 1 | Row-clear strobe |
| row_idx | output | log2(VLEN_BITS/8) | Row to clear |
| done | output | 1 | One-cycle end-of-sequence pulse |
| undef | output | 1 | One-cycle unrecognised-word pulse |

## Verification
The bench drives a command on a falling edge and lets one rising edge accept it. The first row strobe, or the `undef` pulse, is due at the very next falling edge. Each later row is due one falling edge after the one before, and `done` comes one falling edge after the last row. The bench walks this schedule one falling edge at a time and compares each sample with its own list of rows. It then checks one more edge to confirm that nothing extra follows, including after an intrusive command sent mid-sequence.

// File: rtl/tile_rowclr_pkg.sv
// Shared types and helpers for the tile row-clear sequencer.
// Assumes the three command forms differ only in bits 31..15.
package tile_rowclr_pkg;

    typedef enum logic [1:0] {
        MODE_BAD = 2'd0,
        MODE_G1  = 2'd1,
        MODE_G2  = 2'd2,
        MODE_G4  = 2'd3
    } clr_mode_t;

    localparam logic [16:0] OPC_G1 = 17'b11000000000011101;
    localparam logic [16:0] OPC_G2 = 17'b11000000000011110;
    localparam logic [16:0] OPC_G4 = 17'b11000000000011111;

    // log2 of the group count for a mode
    function automatic int unsigned grp_shift(clr_mode_t m);
        case (m)
            MODE_G2: return 1;
            MODE_G4: return 2;
            default: return 0;
        endcase
    endfunction

    // index of the last group for a mode
    function automatic logic [1:0] grp_last(clr_mode_t m);
        case (m)
            MODE_G2: return 2'd1;
            MODE_G4: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tile_rowclr_decode.sv
// Command decoder: classifies a word into one of three forms or bad,
// and extracts the register select field and the scaled offset.
// Purely combinational; assumes the caller qualifies with its valid.
module tile_rowclr_decode
    import tile_rowclr_pkg::*;
(
    input  logic [31:0] word,
    output clr_mode_t   mode,
    output logic [1:0]  rsel,
    output logic [3:0]  offset
);

    // match opcode and must-be-zero fields, scale immediate by four
    always_comb begin
        mode   = MODE_BAD;
        offset = 4'd0;
        rsel   = word[14:13];
        if (word[31:15] == OPC_G1 && word[12:2] == 11'd0) begin
            mode   = MODE_G1;
            offset = {word[1:0], 2'b00};
        end else if (word[31:15] == OPC_G2 && word[12:1] == 12'd0) begin
            mode   = MODE_G2;
            offset = {1'b0, word[0], 2'b00};
        end else if (word[31:15] == OPC_G4 && word[12:1] == 12'd0) begin
            mode   = MODE_G4;
            offset = {1'b0, word[0], 2'b00};
        end
    end

endmodule

// File: rtl/tile_rowclr_addr.sv
// Start-row arithmetic: full 32-bit base plus offset, wrapped to the
// per-group stride by masking, aligned down to four. Also emits the
// stride, truncated to the row width (zero for the single-group form,
// where it is never used). Assumes ROWS is a power of two >= 16.
module tile_rowclr_addr
    import tile_rowclr_pkg::*;
#(
    parameter int ROWS  = 64,
    parameter int ROW_W = 6
) (
    input  logic [31:0]      base,
    input  logic [3:0]       offset,
    input  clr_mode_t        mode,
    output logic [ROW_W-1:0] start,
    output logic [ROW_W-1:0] step
);

    logic [31:0]      sum;
    logic [ROW_W-1:0] mask;
    logic [ROW_W-1:0] wrapped;
    logic             unused_hi;
    int unsigned      stride_i;

    // full-width add of base and offset
    assign sum       = base + {28'd0, offset};
    assign unused_hi = ^sum[31:ROW_W];

    // stride per group, and wrap mask (all ones when one group spans the array)
    always_comb begin
        stride_i = int'(ROWS) >> grp_shift(mode);
        step     = stride_i[ROW_W-1:0];
        mask     = step - ROW_W'(1);
    end

    // wrap and align down to a multiple of four
    assign wrapped = sum[ROW_W-1:0] & mask;
    assign start   = {wrapped[ROW_W-1:2], 2'b00};

endmodule

// File: rtl/tile_rowclr_ctrl.sv
// Sequencer: on launch, captures start, stride and group count, then
// issues one row per cycle, group-major with rows ascending. It pulses
// done after the last row, and registers the bad-word flag.
// Assumes launch and bad are only asserted while idle.
module tile_rowclr_ctrl #(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             bad,
    input  logic [ROW_W-1:0] start,
    input  logic [ROW_W-1:0] step,
    input  logic [1:0]       last_grp,
    output logic             active,
    output logic [ROW_W-1:0] row,
    output logic             fin,
    output logic             err
);

    logic [ROW_W-1:0] grp_base;
    logic [ROW_W-1:0] step_q;
    logic [1:0]       grp_cnt;
    logic [1:0]       last_q;
    logic [1:0]       row_in;

    // sequence state: launch, row/group stepping, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            grp_base <= '0;
            step_q   <= '0;
            grp_cnt  <= 2'd0;
            last_q   <= 2'd0;
            row_in   <= 2'd0;
            fin      <= 1'b0;
            err      <= 1'b0;
        end else begin
            fin <= 1'b0;
            err <= bad;
            if (!active) begin
                if (launch) begin
                    active   <= 1'b1;
                    grp_base <= start;
                    step_q   <= step;
                    grp_cnt  <= 2'd0;
                    last_q   <= last_grp;
                    row_in   <= 2'd0;
                end
            end else begin
                row_in <= row_in + 2'd1;
                if (row_in == 2'd3) begin
                    grp_base <= grp_base + step_q;
                    grp_cnt  <= grp_cnt + 2'd1;
                    if (grp_cnt == last_q) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end
                end
            end
        end
    end

    // row index within the current group
    assign row = grp_base + {{(ROW_W-2){1'b0}}, row_in};

endmodule

// File: rtl/tile_rowclr_seq.sv
// Top of the tile row-clear sequencer. It decodes the command, muxes
// the select register, computes the start row and drives the sequencer.
// Commands are accepted only while idle. VLEN_BITS must be a power of
// two from 128 to 2048.
module tile_rowclr_seq
    import tile_rowclr_pkg::*;
#(
    parameter int VLEN_BITS = 512,
    localparam int ROWS     = VLEN_BITS / 8,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [31:0]      cmd_word,
    input  logic [31:0]      sel_reg0,
    input  logic [31:0]      sel_reg1,
    input  logic [31:0]      sel_reg2,
    input  logic [31:0]      sel_reg3,
    output logic             busy,
    output logic             row_clr,
    output logic [ROW_W-1:0] row_idx,
    output logic             done,
    output logic             undef
);

    clr_mode_t        mode;
    logic [1:0]       rsel;
    logic [3:0]       offset;
    logic [31:0]      bank [4];
    logic [31:0]      base;
    logic [ROW_W-1:0] start;
    logic [ROW_W-1:0] step;
    logic             active;
    logic             accept;

    tile_rowclr_decode u_dec (
        .word   (cmd_word),
        .mode   (mode),
        .rsel   (rsel),
        .offset (offset)
    );

    // select register bank and base mux
    always_comb begin
        bank[0] = sel_reg0;
        bank[1] = sel_reg1;
        bank[2] = sel_reg2;
        bank[3] = sel_reg3;
        base    = bank[rsel];
    end

    tile_rowclr_addr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_addr (
        .base   (base),
        .offset (offset),
        .mode   (mode),
        .start  (start),
        .step   (step)
    );

    // a command is taken only while no sequence runs
    assign accept = cmd_valid && !active;

    tile_rowclr_ctrl #(.ROW_W(ROW_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (accept && mode != MODE_BAD),
        .bad      (accept && mode == MODE_BAD),
        .start    (start),
        .step     (step),
        .last_grp (grp_last(mode)),
        .active   (active),
        .row      (row_idx),
        .fin      (done),
        .err      (undef)
    );

    assign busy    = active;
    assign row_clr = active;

endmodule

// File: rtl/tile_rowclr_chk.sv
// Protocol checker for the tile row-clear sequencer, bound to the top.
module tile_rowclr_chk #(
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             row_clr,
    input logic [ROW_W-1:0] row_idx,
    input logic             done,
    input logic             undef
);

    AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clr && !$past(row_clr)) |-> (row_idx[1:0] == 2'b00)); // R5

    AST_ROW_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clr && $past(row_clr) && row_idx[1:0] != 2'b00)
        |-> (row_idx == $past(row_idx) + ROW_W'(1))); // R6

    AST_LAST_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(row_idx[1:0]) == 2'b11)); // R6

    AST_DONE_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(row_clr) && !row_clr)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!row_clr && !busy)); // R8

endmodule

bind tile_rowclr_seq tile_rowclr_chk #(.ROW_W(ROW_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .row_clr (row_clr),
    .row_idx (row_idx),
    .done    (done),
    .undef   (undef)
);

// File: tb/tile_rowclr_seq_test.sv
module tile_rowclr_seq_test;

    localparam int VLEN  = 512;
    localparam int ROWS  = VLEN / 8;
    localparam int ROW_W = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [31:0]      cmd_word = '0;
    logic [31:0]      regs [4];
    logic             busy, row_clr, done, undef;
    logic [ROW_W-1:0] row_idx;
    int               total = 0;
    int               bad = 0;
    bit               finished = 1'b0;

    always #2.5 clk = ~clk;

    tile_rowclr_seq #(.VLEN_BITS(VLEN)) uut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_word (cmd_word),
        .sel_reg0 (regs[0]), .sel_reg1 (regs[1]), .sel_reg2 (regs[2]), .sel_reg3 (regs[3]),
        .busy (busy), .row_clr (row_clr), .row_idx (row_idx), .done (done), .undef (undef)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // build a word: ng = 1, 2 or 4 groups
    function automatic logic [31:0] mk(int ng, logic [1:0] rv, logic [1:0] imm);
        if (ng == 1) return {17'b11000000000011101, rv, 11'd0, imm};
        if (ng == 2) return {17'b11000000000011110, rv, 12'd0, imm[0]};
        return {17'b11000000000011111, rv, 12'd0, imm[0]};
    endfunction

    // decode per R1..R3: returns group count (0 = unrecognised) and offset
    function automatic int dec(logic [31:0] w, output int off);
        off = 0;
        if (w[31:15] == 17'b11000000000011101 && w[12:2] == 0) begin off = 4 * int'(w[1:0]); return 1; end
        if (w[31:15] == 17'b11000000000011110 && w[12:1] == 0) begin off = 4 * int'(w[0]); return 2; end
        if (w[31:15] == 17'b11000000000011111 && w[12:1] == 0) begin off = 4 * int'(w[0]); return 4; end
        return 0;
    endfunction

    // expected row per R5/R6
    function automatic int exp_row(int ng, logic [31:0] b, int off, int g, int i);
        logic [31:0] s;
        int stride, st;
        stride = ROWS / ng;
        s = b + 32'(off);
        st = int'(s % 32'(stride)) & ~3;
        return st + g * stride + i;
    endfunction

    // issue one command; optionally inject another valid mid-sequence
    task automatic issue(input logic [31:0] w, input logic [31:0] intr, input bit do_intr);
        int off, ng, n, k;
        logic [31:0] b;
        ng = dec(w, off);
        b = regs[w[14:13]];
        @(negedge clk);
        cmd_word = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (ng == 0) begin
            chk(undef == 1'b1, "R8 undef pulse", int'(undef), 1);
            chk(row_clr == 1'b0 && busy == 1'b0, "R8 no strobe", int'(row_clr), 0);
            @(negedge clk);
            chk(undef == 1'b0 && row_clr == 1'b0, "R8 pulse one cycle", int'(undef), 0);
            return;
        end
        n = 4 * ng;
        k = 0;
        for (int g = 0; g < ng; g++) begin
            for (int i = 0; i < 4; i++) begin
                if (k != 0) @(negedge clk);
                cmd_valid = 1'b0;
                chk(row_clr == 1'b1 && busy == 1'b1, "R7/R9 strobe and busy", int'(row_clr), 1);
                chk(int'(row_idx) == exp_row(ng, b, off, g, i), "R5/R6 row index",
                    int'(row_idx), exp_row(ng, b, off, g, i));
                chk(done == 1'b0 && undef == 1'b0, "R9 no flags mid-run", int'(done), 0);
                if (do_intr && k == 1) begin
                    cmd_word = intr;
                    cmd_valid = 1'b1;
                end
                k++;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done == 1'b1 && row_clr == 1'b0 && busy == 1'b0, "R7 done after last row", int'(done), 1);
        chk(k == n, "R1/R2/R3 row count", k, n);
        @(negedge clk);
        chk(done == 1'b0 && row_clr == 1'b0 && undef == 1'b0, "R7/R9 quiet after done", int'(row_clr), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        regs[0] = 32'd0; regs[1] = 32'd0; regs[2] = 32'd0; regs[3] = 32'd0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && row_clr == 0 && done == 0 && undef == 0, "R10 reset state", int'(busy), 0);
        rst_n = 1'b1;

        // R4: each select register, distinct values
        regs[0] = 32'd5; regs[1] = 32'd22; regs[2] = 32'd41; regs[3] = 32'd60;
        for (int r = 0; r < 4; r++) issue(mk(1, 2'(r), 2'd0), '0, 1'b0);
        // R1: 32-bit wrap of base plus offset 12
        regs[2] = 32'hFFFF_FFFF;
        issue(mk(1, 2'd2, 2'd3), '0, 1'b0);
        // R3: quarters, offset 4
        regs[1] = 32'd15;
        issue(mk(4, 2'd1, 2'd1), '0, 1'b0);
        // R2: halves, start at the end of a span
        regs[3] = 32'd31;
        issue(mk(2, 2'd3, 2'd0), '0, 1'b0);
        // R9: intrusions with a valid word and a bad word
        issue(mk(2, 2'd0, 2'd1), mk(4, 2'd1, 2'd0), 1'b1);
        issue(mk(4, 2'd3, 2'd1), 32'h1234_5678, 1'b1);
        // R8: must-be-zero bits and near-miss opcodes
        issue(mk(1, 2'd0, 2'd1) | 32'h0000_0020, '0, 1'b0);
        issue(mk(2, 2'd1, 2'd1) | 32'h0000_0002, '0, 1'b0);
        issue(mk(4, 2'd2, 2'd0) | 32'h0000_1000, '0, 1'b0);
        issue(mk(1, 2'd0, 2'd0) ^ 32'h8000_0000, '0, 1'b0);

        // random mix
        for (int it = 0; it < 80; it++) begin
            int kind;
            logic [31:0] w;
            for (int r = 0; r < 4; r++) regs[r] = $urandom;
            kind = int'($urandom % 8);
            case (kind)
                0, 1: w = mk(1, 2'($urandom), 2'($urandom));
                2, 3: w = mk(2, 2'($urandom), 2'($urandom));
                4, 5: w = mk(4, 2'($urandom), 2'($urandom));
                6:    w = mk(1 << ($urandom % 3), 2'($urandom), 2'd0) | (32'd1 << (2 + $urandom % 11));
                default: w = $urandom;
            endcase
            issue(w, $urandom, 1'($urandom));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule